// File: doc/BRIEF.md
# NAND ECC Control Register Bank

This block sits beside an external memory interface that has four chip-select spaces, called spaces 2 to 5. Software uses a small register bus to switch any of these spaces into NAND mode and to arm an error-correction accumulator for each space. The block watches the byte stream that the interface sends to the external device. For each armed NAND space it folds the bytes into a column and line parity code. The code covers the first 518 bytes after arming, and the accumulator then freezes. Reading a space's result register returns the code. The same read also disarms that space.

The block also routes two configurable external address bits to the NAND command latch enable and address latch enable pins. It masks the wait input for spaces that are in NAND mode. It never produces command, address or data cycles, and it has no output for the write-protect pin.

Top module: `nand_ecc_ctl`

## Requirements
- R1: After reset, every register reads 0: the control word (address 0), the four result words (addresses 1 to 4) and the latch-select word (address 5). Any other address reads 0.
- R2: A write to address 0 loads the mode bits from bits [3:0], with bit i belonging to space i+2. The same write sets the start bit of each space whose bit [8+i] is 1. A 0 in bits [11:8] leaves that start bit as it was. Address 0 reads back the mode bits in [3:0] and the start bits in [11:8].
- R3: A read of address i+1 returns that space's result in the same cycle and clears only that space's start bit. After the start bit is cleared, later transfers leave the result unchanged.
- R4: A transfer (valid, space index 0 to 3 for spaces 2 to 5, byte) updates only the addressed space. It does so only when that space has both its mode bit and its start bit set.
- R5: The result word holds 12 even parity bits in [11:0] and 12 odd parity bits in [27:16]. Each data bit has an index formed from the byte count's lower 9 bits and the bit position: {count[8:0], bit[2:0]}. Odd bit k is the XOR of all data bits whose index has bit k set. Even bit k is the XOR of all data bits whose index has bit k clear.
- R6: Writing 1 to a start bit clears that space's accumulator and byte count, so a later read of the space returns 0 until new bytes arrive.
- R7: After 518 counted bytes the accumulator stops changing, even though the start bit remains set.
- R8: Address 5 holds the command-latch bit index in [2:0] and the address-latch bit index in [10:8]. The CLE output follows the external address bit chosen by the first index, and the ALE output follows the bit chosen by the second.
- R9: The stall output equals the wait input when the space selected on the transfer port is not in NAND mode. It is 0 when that space is in NAND mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a start bit on a result read) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle |
| xfer_valid | input | 1 | One data byte transferred this cycle |
| xfer_cs | input | 2 | Space index of the transfer (0 to 3 for spaces 2 to 5) |
| xfer_byte | input | 8 | Transferred byte |
| ext_addr | input | 8 | External address lines |
| ext_wait | input | 1 | Wait input from the device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| wait_stall | output | 1 | Wait input after NAND masking |

## Verification
The accumulators are driven with several byte streams, and each stream separates a different fault:
- A short stream goes to an armed space while the other spaces are left unarmed or not in NAND mode, one condition each. This shows whether gating and per-space isolation hold.
- A deterministic mixed-value stream of more than 518 bytes goes to one space. Bytes past the limit expose a missing freeze, and bytes near count 512 expose errors in the line-parity index.
- A space is disarmed by a read and then a re-arm stream is sent. This separates the clear-on-read behaviour from the clear-on-arm behaviour.
- The external address and wait inputs are swept while the mode bits differ across spaces, which checks the latch selection and the wait masking.

// File: rtl/nand_ecc_ctl.sv
module nand_ecc_ctl #(
  parameter int NCS       = 4,
  parameter int BYTE_W    = 8,
  parameter int LINE_W    = 9,
  parameter int ECC_BYTES = 518,
  parameter int EXT_AW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 xfer_valid,
  input  logic [1:0]           xfer_cs,
  input  logic [BYTE_W-1:0]    xfer_byte,
  input  logic [EXT_AW-1:0]    ext_addr,
  input  logic                 ext_wait,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 wait_stall
);
  localparam int RAW  = 3;
  localparam int CSW  = 2;
  localparam int COLW = $clog2(BYTE_W);
  localparam int PW   = COLW + LINE_W;
  localparam int CNTW = $clog2(ECC_BYTES + 1);
  localparam int SELW = $clog2(EXT_AW);

  logic [NCS-1:0]  mode_q, start_q;
  logic [CNTW-1:0] cnt_q  [NCS];
  logic [PW-1:0]   even_q [NCS];
  logic [PW-1:0]   odd_q  [NCS];
  logic [PW-1:0]   ev_c   [NCS];
  logic [PW-1:0]   od_c   [NCS];
  logic [SELW-1:0] cle_sel_q, ale_sel_q;

  wire ctrl_wr = reg_wr && reg_addr == RAW'(0);
  wire sel_wr  = reg_wr && reg_addr == RAW'(NCS + 1);
  wire bpar    = ^xfer_byte;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      ev_c[i] = '0;
      od_c[i] = '0;
      for (int k = 0; k < COLW; k++)
        for (int b = 0; b < BYTE_W; b++)
          if (((b >> k) & 1) == 1) od_c[i][k] = od_c[i][k] ^ xfer_byte[b];
          else                     ev_c[i][k] = ev_c[i][k] ^ xfer_byte[b];
      for (int j = 0; j < LINE_W; j++)
        if (cnt_q[i][j]) od_c[i][COLW+j] = bpar;
        else             ev_c[i][COLW+j] = bpar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      start_q   <= '0;
      cle_sel_q <= '0;
      ale_sel_q <= '0;
      for (int i = 0; i < NCS; i++) begin
        cnt_q[i]  <= '0;
        even_q[i] <= '0;
        odd_q[i]  <= '0;
      end
    end else begin
      if (ctrl_wr) mode_q <= reg_wdata[NCS-1:0];
      if (sel_wr) begin
        cle_sel_q <= reg_wdata[SELW-1:0];
        ale_sel_q <= reg_wdata[8 +: SELW];
      end
      for (int i = 0; i < NCS; i++) begin
        if (ctrl_wr && reg_wdata[8+i]) begin
          start_q[i] <= 1'b1;
          cnt_q[i]   <= '0;
          even_q[i]  <= '0;
          odd_q[i]   <= '0;
        end else begin
          if (reg_rd && reg_addr == RAW'(i + 1)) start_q[i] <= 1'b0;
          if (xfer_valid && xfer_cs == CSW'(i) && mode_q[i] && start_q[i]
              && cnt_q[i] < CNTW'(ECC_BYTES)) begin
            cnt_q[i]  <= cnt_q[i] + 1'b1;
            even_q[i] <= even_q[i] ^ ev_c[i];
            odd_q[i]  <= odd_q[i] ^ od_c[i];
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(0)) begin
      reg_rdata[NCS-1:0]  = mode_q;
      reg_rdata[8 +: NCS] = start_q;
    end else if (reg_addr == RAW'(NCS + 1)) begin
      reg_rdata[SELW-1:0]  = cle_sel_q;
      reg_rdata[8 +: SELW] = ale_sel_q;
    end else begin
      for (int i = 0; i < NCS; i++)
        if (reg_addr == RAW'(i + 1)) begin
          reg_rdata[PW-1:0]  = even_q[i];
          reg_rdata[16 +: PW] = odd_q[i];
        end
    end
  end

  assign nand_cle   = ext_addr[cle_sel_q];
  assign nand_ale   = ext_addr[ale_sel_q];
  assign wait_stall = ext_wait && !mode_q[xfer_cs];
endmodule

// File: rtl/nand_ecc_ctl_chk.sv
module nand_ecc_ctl_chk #(
  parameter int NCS = 4, ECC_BYTES = 518, RAW = 3, CNTW = 10, PW = 12, CSW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [RAW-1:0]  reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            ext_wait,
  input logic            wait_stall,
  input logic [CSW-1:0]  xfer_cs,
  input logic [NCS-1:0]  mode_q,
  input logic [NCS-1:0]  start_q,
  input logic [CNTW-1:0] cnt0,
  input logic [PW-1:0]   even0,
  input logic [PW-1:0]   odd0
);
  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == RAW'(1)) |=> !start_q[0]);
  // R6
  rearm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RAW'(0) && reg_wdata[8]) |=> (start_q[0] && cnt0 == '0 && even0 == '0 && odd0 == '0));
  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0 <= CNTW'(ECC_BYTES));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mode_q[0] && start_q[0]) && !(reg_wr && reg_addr == RAW'(0))) |=> ($stable(even0) && $stable(odd0) && $stable(cnt0)));
  // R2
  start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q[0]) |-> $past(reg_wr && reg_addr == RAW'(0)));
  // R9
  nand_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[xfer_cs] || !ext_wait) |-> !wait_stall);
endmodule

bind nand_ecc_ctl nand_ecc_ctl_chk #(
  .NCS(NCS), .ECC_BYTES(ECC_BYTES), .RAW(RAW), .CNTW(CNTW), .PW(PW), .CSW(CSW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ext_wait(ext_wait), .wait_stall(wait_stall), .xfer_cs(xfer_cs),
  .mode_q(mode_q), .start_q(start_q), .cnt0(cnt_q[0]), .even0(even_q[0]), .odd0(odd_q[0])
);

// File: tb/nand_ecc_ctl_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, reg_wr, reg_rd, xfer_valid, ext_wait;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [1:0]  xfer_cs;
  logic [7:0]  xfer_byte, ext_addr;
  logic        nand_cle, nand_ale, wait_stall;

  nand_ecc_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_valid(xfer_valid),
    .xfer_cs(xfer_cs), .xfer_byte(xfer_byte), .ext_addr(ext_addr), .ext_wait(ext_wait),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .wait_stall(wait_stall)
  );

  int checks = 0, errors = 0;
  int m_mode[4], m_start[4], m_cnt[4], m_even[4], m_odd[4];
  int m_cle = 0, m_ale = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] r = '0;
    if (a == 0) for (int i = 0; i < 4; i++) begin
      r[i] = m_mode[i][0]; r[8+i] = m_start[i][0];
    end else if (a >= 1 && a <= 4) begin
      r[11:0] = m_even[a-1][11:0]; r[27:16] = m_odd[a-1][11:0];
    end else if (a == 5) begin
      r[2:0] = m_cle[2:0]; r[10:8] = m_ale[2:0];
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 0; m_start[i] = 0; m_cnt[i] = 0; m_even[i] = 0; m_odd[i] = 0;
    end
    m_cle = 0; m_ale = 0;
  endtask

  task automatic model_clock();
    bit hit[4];
    for (int i = 0; i < 4; i++)
      hit[i] = xfer_valid && xfer_cs == i && m_mode[i] == 1 && m_start[i] == 1 && m_cnt[i] < 518;
    for (int i = 0; i < 4; i++) begin
      if (reg_wr && reg_addr == 0 && reg_wdata[8+i]) begin
        m_start[i] = 1; m_cnt[i] = 0; m_even[i] = 0; m_odd[i] = 0;
      end else begin
        if (reg_rd && reg_addr == i + 1) m_start[i] = 0;
        if (hit[i]) begin
          for (int b = 0; b < 8; b++)
            if (xfer_byte[b]) begin
              int idx = ((m_cnt[i] & 511) << 3) | b;
              for (int k = 0; k < 12; k++)
                if ((idx >> k) & 1) m_odd[i] ^= (1 << k);
                else                m_even[i] ^= (1 << k);
            end
          m_cnt[i]++;
        end
      end
    end
    if (reg_wr && reg_addr == 0) for (int i = 0; i < 4; i++) m_mode[i] = reg_wdata[i];
    if (reg_wr && reg_addr == 5) begin m_cle = reg_wdata[2:0]; m_ale = reg_wdata[10:8]; end
  endtask

  task automatic step(string tag);
    logic [31:0] e;
    bit es;
    #1;
    e = exp_rd(reg_addr);
    chk(reg_rdata == e, tag, reg_rdata, e);
    chk(nand_cle == ext_addr[m_cle] && nand_ale == ext_addr[m_ale], "R8",
        {nand_cle, nand_ale}, {ext_addr[m_cle], ext_addr[m_ale]});
    es = ext_wait && m_mode[xfer_cs] == 0;
    chk(wait_stall == es, "R9", wait_stall, es);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; xfer_valid = 0;
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    reg_wr = 1; reg_addr = a[2:0]; reg_wdata = d; step(tag);
  endtask

  task automatic rd(int a, string tag);
    reg_rd = 1; reg_addr = a[2:0]; step(tag);
  endtask

  task automatic send(int cs, int n, int seed, string tag);
    for (int j = 0; j < n; j++) begin
      xfer_valid = 1; xfer_cs = cs[1:0]; xfer_byte = 8'((j * 37 + seed) ^ (j >> 3));
      step(tag);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    xfer_valid = 0; xfer_cs = 0; xfer_byte = 0; ext_addr = 0; ext_wait = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd(a, "R1");

    wr(5, 32'h0000_0503, "R8");
    for (int v = 0; v < 8; v++) begin ext_addr = 8'(1 << v); rd(5, "R8"); end
    ext_addr = 8'hA5; rd(5, "R8");

    wr(0, 32'h0000_0105, "R2");
    rd(0, "R2");
    ext_wait = 1;
    for (int c = 0; c < 4; c++) begin xfer_cs = c[1:0]; rd(0, "R9"); end
    ext_wait = 0;

    send(0, 20, 11, "R5");
    send(1, 7, 3, "R4");
    send(2, 9, 5, "R4");
    rd(1, "R5"); rd(2, "R4"); rd(3, "R4"); rd(0, "R3");

    wr(0, 32'h0000_0F0F, "R2");
    send(3, 530, 91, "R7");
    rd(4, "R7");
    rd(0, "R7");
    send(3, 4, 200, "R7");
    rd(4, "R7");

    rd(1, "R3");
    rd(0, "R3");
    send(0, 6, 17, "R3");
    rd(1, "R3");
    rd(2, "R5");

    wr(0, 32'h0000_000F, "R2");
    rd(0, "R2");
    send(1, 5, 9, "R2");
    rd(2, "R2");

    wr(0, 32'h0000_080F, "R6");
    rd(4, "R6");
    send(3, 5, 44, "R6");
    rd(4, "R6");

    rst_n = 0; @(negedge clk); rst_n = 1; model_reset();
    for (int a = 0; a < 6; a++) rd(a, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule